// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns one operand in an unpacked internal floating-point form into a signed two's-complement integer. The result is 32 bits wide by default, and a parameter widens it to 64 bits. Each operand carries four things: a sign, a 3-bit class code, a signed unbiased exponent, and a mantissa. The mantissa has an explicit leading one, the fraction bits, two guard/round bits and a separate sticky flag. The conversion always truncates toward zero. It raises inexact when any nonzero bit is discarded. When the value cannot be represented it raises invalid instead and returns a saturation value that depends on the sign.

Operands arrive on a valid/ready stream and results leave on another. One operand is accepted per cycle whenever the output register is empty or is being drained in that cycle. The converted result appears in the output register in the cycle after acceptance. Back-pressure works as follows:
- `in_ready` equals `!out_valid || out_ready`.
- A held result keeps its data and flags until the downstream side takes it.
- A new operand replaces the result only in a cycle where the old one is consumed.

Top module: `fti_conv`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_int`, `out_inexact` and `out_invalid` to 0.
- R2: An operand is accepted when `in_valid && in_ready`, with `in_ready = !out_valid || out_ready`. Its result shows `out_valid` high in the next cycle. While `out_valid && !out_ready`, the outputs hold steady, and results leave in acceptance order.
- R3: Class code 0 (zero) yields result 0 with both flags clear, whatever the sign, exponent and mantissa fields hold.
- R4: For class code 1 (number), the value is mantissa × 2^(exponent − 66). Mantissa bit 66 is the integer one, bits 65:2 are the fraction, and bits 1:0 are guard/round. An in-range value is truncated toward zero. A negative sign gives the two's-complement negation of the magnitude.
- R5: For an in-range number, inexact is set if and only if a discarded mantissa bit or the sticky flag is nonzero.
- R6: A number with a negative exponent gives 0. Inexact is set if and only if the mantissa or sticky is nonzero.
- R7: A number whose exponent is at least the result width is an overflow.
- R8: A truncated magnitude at or above 2^(W−1) + sign is an overflow. A negative operand may therefore reach exactly −2^(W−1) without overflowing.
- R9: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are overflows.
- R10: On overflow, invalid is set and inexact is clear. The result is 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one; the 64-bit variant uses the corresponding 64-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_cls | input | 3 | Class code |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 67 | Integer one, fraction, guard/round bits |
| in_sticky | input | 1 | OR of bits below the mantissa |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_int | output | RES_W | Signed integer result |
| out_inexact | output | 1 | Nonzero bits were discarded |
| out_invalid | output | 1 | Operand not representable |

## Verification
The only state in the block is the output register and its valid bit, so a fault in either one is visible at the ports within one cycle. A wrong load shows up in `out_int` or a flag in the cycle after acceptance. A wrong valid bit shows up as a lost, duplicated or reordered result at the next handshake. A held result that drifts during a stall is visible in the stalled cycle itself. A datapath error is visible only for operands on the affected side of a boundary, so the stimulus sits at exponents −1, 0, 30, 31 and 32, at exactly −2^31, and on single discarded bits.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NUM  = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;
endpackage

// File: rtl/fti_align.sv
// Moves the integer part of the mantissa into the low bits and gathers
// everything that falls off into one lost-bit flag.
module fti_align #(
  parameter int FRAC_W = 64,
  parameter int EXP_W  = 16,
  parameter int RES_W  = 32
) (
  input  logic [EXP_W-1:0]    exp_i,
  input  logic [FRAC_W+2:0]   mant_i,
  input  logic                sticky_i,
  output logic [RES_W-1:0]    mag_o,
  output logic                lost_o,
  output logic                big_o
);
  localparam int MANT_W = FRAC_W + 3;
  localparam int PT     = FRAC_W + 2;
  localparam int SH_W   = $clog2(MANT_W + 1);

  logic             neg;
  logic [SH_W-1:0]  sh;
  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] keep_mask;

  always_comb begin
    neg       = exp_i[EXP_W-1];
    big_o     = !neg && (exp_i >= EXP_W'(RES_W));
    sh        = SH_W'(PT) - exp_i[SH_W-1:0];
    shifted   = mant_i >> sh;
    keep_mask = {MANT_W{1'b1}} << sh;
    mag_o     = '0;
    lost_o    = 1'b0;
    if (neg) begin
      lost_o = (|mant_i) | sticky_i;
    end else if (!big_o) begin
      mag_o  = shifted[RES_W-1:0];
      lost_o = (|(mant_i & ~keep_mask)) | sticky_i;
    end
  end
endmodule

// File: rtl/fti_select.sv
// Picks the final value and flags from the class, sign and aligned magnitude.
module fti_select
  import fti_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic             sign_i,
  input  logic [2:0]       cls_i,
  input  logic [RES_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             big_i,
  output logic [RES_W-1:0] res_o,
  output logic             nx_o,
  output logic             nv_o
);
  localparam logic [RES_W-1:0] SAT_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SAT_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W:0] limit;
  logic           ovf;

  always_comb begin
    limit = {1'b0, SAT_NEG} + (RES_W+1)'(sign_i);
    ovf   = 1'b1;
    if (cls_i == CLS_ZERO)     ovf = 1'b0;
    else if (cls_i == CLS_NUM) ovf = big_i || ({1'b0, mag_i} >= limit);

    res_o = '0;
    nx_o  = 1'b0;
    nv_o  = 1'b0;
    if (ovf) begin
      nv_o  = 1'b1;
      res_o = sign_i ? SAT_NEG : SAT_POS;
    end else if (cls_i == CLS_NUM) begin
      nx_o  = lost_i;
      res_o = sign_i ? (~mag_i + 1'b1) : mag_i;
    end
  end
endmodule

// File: rtl/fti_conv.sv
module fti_conv
  import fti_pkg::*;
#(
  parameter int FRAC_W = 64,
  parameter int EXP_W  = 16,
  parameter int RES_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sign,
  input  logic [2:0]         in_cls,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [FRAC_W+2:0]  in_mant,
  input  logic               in_sticky,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RES_W-1:0]   out_int,
  output logic               out_inexact,
  output logic               out_invalid
);
  localparam logic [RES_W-1:0] SAT_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SAT_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mag, res;
  logic             lost, big, nx, nv, accept;

  fti_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .RES_W(RES_W)) align_i (
    .exp_i(in_exp), .mant_i(in_mant), .sticky_i(in_sticky),
    .mag_o(mag), .lost_o(lost), .big_o(big)
  );

  fti_select #(.RES_W(RES_W)) select_i (
    .sign_i(in_sign), .cls_i(in_cls), .mag_i(mag), .lost_i(lost), .big_i(big),
    .res_o(res), .nx_o(nx), .nv_o(nv)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_int     <= res;
      out_inexact <= nx;
      out_invalid <= nv;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R2
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int)
      && $stable(out_inexact) && $stable(out_invalid)));
  // R3
  zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_cls == CLS_ZERO) |=> (out_int == '0 && !out_inexact && !out_invalid));
  // R7
  big_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_cls == CLS_NUM && !in_exp[EXP_W-1] && in_exp >= EXP_W'(RES_W))
      |=> out_invalid);
  // R9
  nonnum_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_cls >= CLS_INF) |=> out_invalid);
  // R10
  sat_val_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (!out_inexact && (out_int == SAT_POS || out_int == SAT_NEG)));
endmodule

// File: tb/fti_conv_tb.sv
`timescale 1ns/1ps
module fti_conv_tb_top;
  typedef struct {
    logic [31:0] v;
    bit          nx;
    bit          nv;
    string       tag;
  } exp_t;

  localparam logic [66:0] ONE   = 67'h4_0000_0000_0000_0000;
  localparam logic [66:0] ALL1  = 67'h7_FFFF_FFFF_FFFF_FFFF;

  logic        clk = 0, rst = 1;
  logic        in_valid = 0, in_sign = 0, in_sticky = 0, out_ready = 0;
  logic [2:0]  in_cls = 0;
  logic [15:0] in_exp = 0;
  logic [66:0] in_mant = 0;
  logic        in_ready, out_valid, out_inexact, out_invalid;
  logic [31:0] out_int;

  int   checks = 0, fails = 0, cyc = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  fti_conv dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_cls(in_cls), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  // back-pressure pattern: ready drops one cycle in three
  initial begin
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      cyc++;
      out_ready = (cyc % 3) != 0;
      @(negedge clk);
    end
  end

  task automatic send(input bit s, input logic [2:0] c, input logic [15:0] e,
                      input logic [66:0] m, input bit st,
                      input logic [31:0] ev, input bit enx, input bit env,
                      input string tag);
    exp_t it;
    @(negedge clk);
    in_valid = 1; in_sign = s; in_cls = c; in_exp = e; in_mant = m; in_sticky = st;
    it.v = ev; it.nx = enx; it.nv = env; it.tag = tag;
    forever begin
      #1;
      if (in_ready) begin
        q.push_back(it);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  bit          prev_stall = 0;
  logic [31:0] prev_int;
  logic        prev_nx, prev_nv;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_int !== prev_int || out_inexact !== prev_nx || out_invalid !== prev_nv) begin
          fails++;
          $display("FAIL R2 stall hold: actual v=%0b int=%h nx=%0b nv=%0b expected v=1 int=%h nx=%0b nv=%0b",
                   out_valid, out_int, out_inexact, out_invalid, prev_int, prev_nx, prev_nv);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected result: actual int=%h expected none", out_int);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_int !== e.v || out_inexact !== e.nx || out_invalid !== e.nv) begin
            fails++;
            $display("FAIL %s: actual int=%h nx=%0b nv=%0b expected int=%h nx=%0b nv=%0b",
                     e.tag, out_int, out_inexact, out_invalid, e.v, e.nx, e.nv);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_int = out_int; prev_nx = out_inexact; prev_nv = out_invalid;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== 0 || out_inexact !== 0 || out_invalid !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual v=%0b int=%h nx=%0b nv=%0b expected all 0",
               out_valid, out_int, out_inexact, out_invalid);
    end
    rst = 0;

    // R3 zero class ignores other fields
    send(1, 3'd0, 16'd5, ALL1, 1, 32'h0, 0, 0, "R3 zero class");
    // R4 truncation, both signs; R5 exact vs inexact
    send(0, 3'd1, 16'd0, ONE, 0, 32'd1, 0, 0, "R4 one exact");
    send(0, 3'd1, 16'd2, 67'h5_C000_0000_0000_0000, 0, 32'd5, 1, 0, "R4 5.75 trunc");
    send(1, 3'd1, 16'd2, 67'h5_C000_0000_0000_0000, 0, 32'hFFFF_FFFB, 1, 0, "R4 -5.75 trunc");
    send(0, 3'd1, 16'd2, 67'h6_0000_0000_0000_0000, 0, 32'd6, 0, 0, "R5 6.0 exact");
    send(1, 3'd1, 16'd2, 67'h6_0000_0000_0000_0000, 0, 32'hFFFF_FFFA, 0, 0, "R4 -6.0 exact");
    send(0, 3'd1, 16'd0, ONE, 1, 32'd1, 1, 0, "R5 sticky only");
    send(0, 3'd1, 16'd0, 67'h4_0000_0000_0000_0001, 0, 32'd1, 1, 0, "R5 round bit only");
    send(0, 3'd1, 16'd30, ALL1, 0, 32'h7FFF_FFFF, 1, 0, "R4 max positive");
    // R8 boundary at 2^31
    send(1, 3'd1, 16'd31, ONE, 0, 32'h8000_0000, 0, 0, "R8 exact -2^31");
    send(1, 3'd1, 16'd31, ONE, 1, 32'h8000_0000, 1, 0, "R8 -2^31 with sticky");
    send(0, 3'd1, 16'd31, ONE, 0, 32'h7FFF_FFFF, 0, 1, "R8 +2^31 overflow");
    send(1, 3'd1, 16'd31, 67'h4_0000_0008_0000_0000, 0, 32'h8000_0000, 0, 1, "R8 -(2^31+1) overflow");
    // R7 large exponent; R10 inexact replaced by invalid
    send(0, 3'd1, 16'd32, ONE, 0, 32'h7FFF_FFFF, 0, 1, "R7 exp 32");
    send(1, 3'd1, 16'h7FFF, ONE, 0, 32'h8000_0000, 0, 1, "R7 exp max neg");
    send(0, 3'd1, 16'd40, ALL1, 1, 32'h7FFF_FFFF, 0, 1, "R10 overflow clears inexact");
    // R6 negative exponents
    send(0, 3'd1, 16'hFFFF, ONE, 0, 32'h0, 1, 0, "R6 0.5");
    send(1, 3'd1, 16'hFFFF, ONE, 0, 32'h0, 1, 0, "R6 -0.5");
    send(0, 3'd1, 16'h8000, ONE, 0, 32'h0, 1, 0, "R6 min exponent");
    send(0, 3'd1, 16'hFFFD, 67'h0, 0, 32'h0, 0, 0, "R6 zero mantissa exact");
    send(0, 3'd1, 16'hFFFD, 67'h0, 1, 32'h0, 1, 0, "R6 sticky only");
    // R9 non-numeric classes
    send(0, 3'd2, 16'd0, ONE, 0, 32'h7FFF_FFFF, 0, 1, "R9 +inf");
    send(1, 3'd2, 16'd0, ONE, 0, 32'h8000_0000, 0, 1, "R9 -inf");
    send(0, 3'd3, 16'd0, ALL1, 1, 32'h7FFF_FFFF, 0, 1, "R9 qnan");
    send(1, 3'd4, 16'd0, ALL1, 0, 32'h8000_0000, 0, 1, "R9 snan");
    send(0, 3'd5, 16'd0, ONE, 0, 32'h7FFF_FFFF, 0, 1, "R9 code 5");
    send(1, 3'd7, 16'd0, ONE, 0, 32'h8000_0000, 0, 1, "R9 code 7");
    send(0, 3'd0, 16'd31, ONE, 0, 32'h0, 0, 0, "R3 zero after overflow");
    @(negedge clk);
    in_valid = 0;

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual pending=%0d expected 0", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule